// File: doc/BRIEF.md
# Pipelined Sine and Cosine Generator

This block turns a stream of angles into their cosine and sine. Each angle passes through a chain of fixed rotation stages. Every stage applies one shift-and-add micro-rotation, and a register sits between each stage and the next. A new angle can therefore enter on every clock, and its result appears a fixed number of cycles later. A valid flag travels beside the data, so the stream may contain gaps.

Each stage shifts its operands by a constant amount, so no barrel shifter is needed. The rotation gain is cancelled by starting the X operand at the precomputed gain constant, which removes any output multiplier. Angles whose magnitude exceeds a right angle are first folded by half a turn. Both results are negated when they leave the last stage.

Top module: `sincos_pipe`

## Requirements
- R1: `angle_i` is a 16-bit two's complement binary angle with 1 LSB = π/32768. The code range therefore covers −π up to just below +π, and codes wrap modulo one full turn.
- R2: `cos_o` and `sin_o` are signed Q1.14 values, where 16384 means +1.0. Each lies within 4 LSB of the correctly rounded cosine and sine of the accepted angle.
- R3: The result for an angle accepted at a rising edge (with `angle_vld_i` high) appears at the 16th rising edge after it, with `res_vld_o` high.
- R4: A new angle may be accepted on every clock. Back-to-back angles produce back-to-back results in the same order.
- R5: An angle whose two most significant bits differ lies outside [−π/2, π/2). Such an angle is shifted by half a turn before rotation, and both outputs are negated. Examples are the codes for +π/2, −π and 3π/4.
- R6: `res_vld_o` is high only for cycles that correspond to accepted angles. Input gaps reappear as output gaps in the same positions.
- R7: Reset is synchronous and active low. A clock edge with `rst_n` low clears every in-flight valid flag, so angles already in the pipeline produce no result afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| angle_vld_i | input | 1 | Angle on `angle_i` is accepted this cycle |
| angle_i | input | 16 | Binary angle, π/32768 per LSB |
| res_vld_o | output | 1 | `cos_o` and `sin_o` hold a result |
| cos_o | output | 16 | Cosine, signed Q1.14 |
| sin_o | output | 16 | Sine, signed Q1.14 |

## Verification
The hardest situation to reach from the ports is a reset that lands while the pipeline holds a mix of valid and empty slots. The flush must then remove every pending result and leave nothing stale behind. The stimulus fills part of the pipeline with angles, pulses reset before any of them can emerge, and then watches a full latency window of idle cycles. Folding cases are reached by driving the exact quadrant-boundary codes (±π/2, −π, the largest positive code) and a full-turn sweep with a step that lands in every quadrant.

// File: rtl/sincos_pkg.sv
// sincos_pkg: constant functions shared by the sine/cosine pipeline.
// Assumes angles are binary angles (half a turn = 2**(aw-1) codes) and
// that all results are elaboration-time constants.
package sincos_pkg;

    localparam real PI_C = 3.14159265358979323846;

    // Micro-rotation angle atan(2**-idx), expressed in binary-angle codes.
    function automatic int angle_step(input int idx, input int aw);
        real r;
        r = $atan(2.0 ** (-idx)) * (2.0 ** (aw - 1)) / PI_C;
        return $rtoi(r + 0.5);
    endfunction

    // Largest residual angle expected after stage idx, with rounding slack.
    function automatic int residual_limit(input int idx, input int stages, input int aw);
        int acc;
        acc = 0;
        for (int j = idx + 1; j < stages; j++) begin
            acc += angle_step(j, aw);
        end
        return acc + stages;
    endfunction

    // Inverse of the accumulated rotation gain, scaled by 2**frac.
    function automatic int gain_seed(input int stages, input int frac);
        real g;
        g = 1.0;
        for (int j = 0; j < stages; j++) begin
            g = g / $sqrt(1.0 + 2.0 ** (-2 * j));
        end
        return $rtoi(g * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/sincos_fold.sv
// sincos_fold: brings any binary angle into [-pi/2, pi/2) by adding half a
// turn when the two top bits differ, and flags that the results must be
// negated. Purely combinational; assumes AW >= 3.
module sincos_fold #(
    parameter int AW = 16,
    parameter int ZW = AW + 1
) (
    input  logic [AW-1:0]        angle_i,
    output logic signed [ZW-1:0] z_o,
    output logic                 flip_o
);

    localparam int QUARTER = 2 ** (AW - 2);

    logic [AW-1:0] folded;

    // Fold the angle by half a turn when it lies in the rear half-plane.
    always_comb begin
        flip_o = angle_i[AW-1] ^ angle_i[AW-2];
        folded = {angle_i[AW-1] ^ flip_o, angle_i[AW-2:0]};
        z_o    = {{(ZW - AW){folded[AW-1]}}, folded};
    end

    // R5: the folded angle must sit inside the convergence range.
    always_comb begin
        p_fold_range_r5: assert (z_o >= -QUARTER && z_o < QUARTER);
    end

endmodule

// File: rtl/sincos_stage.sv
// sincos_stage: one registered rotation-mode micro-rotation with a fixed
// shift SHIFT and fixed angle STEP. The direction follows the sign of the
// incoming residual angle. Valid and fold flags are carried unchanged.
module sincos_stage #(
    parameter int XW     = 18,
    parameter int ZW     = 17,
    parameter int SHIFT  = 0,
    parameter int STEP   = 0,
    parameter int LIMIT  = 0,
    parameter int MAGMAX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic                 flip_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 vld_q,
    output logic                 flip_q,
    output logic signed [XW-1:0] x_q,
    output logic signed [XW-1:0] y_q,
    output logic signed [ZW-1:0] z_q
);

    localparam logic signed [ZW-1:0] STEP_Z = ZW'(STEP);

    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;

    // Hard-wired arithmetic shifts of the operands.
    always_comb begin
        x_sh = x_i >>> SHIFT;
        y_sh = y_i >>> SHIFT;
    end

    // Rotate toward zero residual and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            flip_q <= 1'b0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
        end else begin
            vld_q  <= vld_i;
            flip_q <= flip_i;
            if (!z_i[ZW-1]) begin
                x_q <= x_i - y_sh;
                y_q <= y_i + x_sh;
                z_q <= z_i - STEP_Z;
            end else begin
                x_q <= x_i + y_sh;
                y_q <= y_i - x_sh;
                z_q <= z_i + STEP_Z;
            end
        end
    end

    // R6: a valid flag moves exactly one stage per clock.
    p_valid_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_q);

    // R2: the residual angle shrinks within the remaining rotation budget.
    p_residual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (z_q <= LIMIT && z_q >= -LIMIT));

    // R2: the rotated vector never grows beyond unit length plus slack.
    p_magnitude_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (x_q <= MAGMAX && x_q >= -MAGMAX && y_q <= MAGMAX && y_q >= -MAGMAX));

endmodule

// File: rtl/sincos_post.sv
// sincos_post: rounds the guard bits off the final vector and negates it
// when the input angle was folded. Combinational; assumes XW > AW.
module sincos_post #(
    parameter int AW = 16,
    parameter int XW = 18
) (
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic                 flip_i,
    output logic signed [AW-1:0] cos_o,
    output logic signed [AW-1:0] sin_o
);

    localparam int GUARD = XW - AW;
    localparam int ONE   = 2 ** (AW - 2);

    logic signed [XW-1:0] x_rnd;
    logic signed [XW-1:0] y_rnd;
    logic signed [AW-1:0] x_out;
    logic signed [AW-1:0] y_out;

    // Round to nearest, then apply the fold correction.
    always_comb begin
        x_rnd = (x_i + XW'(2 ** (GUARD - 1))) >>> GUARD;
        y_rnd = (y_i + XW'(2 ** (GUARD - 1))) >>> GUARD;
        x_out = x_rnd[AW-1:0];
        y_out = y_rnd[AW-1:0];
        cos_o = flip_i ? -x_out : x_out;
        sin_o = flip_i ? -y_out : y_out;
    end

    // R2: the results stay within the unit range plus rounding slack.
    always_comb begin
        p_out_range_r2: assert (cos_o <= ONE + 2 && cos_o >= -ONE - 2 &&
                                sin_o <= ONE + 2 && sin_o >= -ONE - 2);
    end

endmodule

// File: rtl/sincos_pipe.sv
// sincos_pipe: fully unrolled rotation-mode pipeline producing cosine and
// sine of a binary angle, one result per clock, STAGES cycles after input.
// Assumes STAGES < AW + GUARD so every shift keeps at least the sign bit.
module sincos_pipe #(
    parameter int AW     = 16,
    parameter int STAGES = 16,
    parameter int GUARD  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 angle_vld_i,
    input  logic [AW-1:0]        angle_i,
    output logic                 res_vld_o,
    output logic signed [AW-1:0] cos_o,
    output logic signed [AW-1:0] sin_o
);

    localparam int XW     = AW + GUARD;
    localparam int ZW     = AW + 1;
    localparam int FRAC   = AW - 2 + GUARD;
    localparam int SEED   = sincos_pkg::gain_seed(STAGES, FRAC);
    localparam int MAGMAX = 2 ** FRAC + 2 * STAGES;

    logic                 vld_c  [STAGES+1];
    logic                 flip_c [STAGES+1];
    logic signed [XW-1:0] x_c    [STAGES+1];
    logic signed [XW-1:0] y_c    [STAGES+1];
    logic signed [ZW-1:0] z_c    [STAGES+1];

    sincos_fold #(
        .AW (AW),
        .ZW (ZW)
    ) u_fold (
        .angle_i (angle_i),
        .z_o     (z_c[0]),
        .flip_o  (flip_c[0])
    );

    // Seed the chain: gain-compensated unit vector on the X axis.
    always_comb begin
        vld_c[0] = angle_vld_i;
        x_c[0]   = XW'(SEED);
        y_c[0]   = '0;
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        sincos_stage #(
            .XW     (XW),
            .ZW     (ZW),
            .SHIFT  (g),
            .STEP   (sincos_pkg::angle_step(g, AW)),
            .LIMIT  (sincos_pkg::residual_limit(g, STAGES, AW)),
            .MAGMAX (MAGMAX)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_c[g]),
            .flip_i (flip_c[g]),
            .x_i    (x_c[g]),
            .y_i    (y_c[g]),
            .z_i    (z_c[g]),
            .vld_q  (vld_c[g+1]),
            .flip_q (flip_c[g+1]),
            .x_q    (x_c[g+1]),
            .y_q    (y_c[g+1]),
            .z_q    (z_c[g+1])
        );
    end

    sincos_post #(
        .AW (AW),
        .XW (XW)
    ) u_post (
        .x_i    (x_c[STAGES]),
        .y_i    (y_c[STAGES]),
        .flip_i (flip_c[STAGES]),
        .cos_o  (cos_o),
        .sin_o  (sin_o)
    );

    // Result valid is the flag leaving the last stage.
    always_comb begin
        res_vld_o = vld_c[STAGES];
    end

    // R7: one clock in reset empties the output slot.
    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> !res_vld_o);

endmodule

// File: tb/sincos_pipe_bench.sv
// sincos_pipe_bench: behavioural reference with a history queue; every
// clock the output is compared with the angle driven LAT cycles earlier.
module sincos_pipe_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 16;
    localparam int TOL        = 4;
    localparam real PI_B      = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               angle_vld_i;
    logic [15:0]        angle_i;
    logic               res_vld_o;
    logic signed [15:0] cos_o;
    logic signed [15:0] sin_o;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    bit    hv[$];
    int    ha[$];
    string ht[$];

    sincos_pipe u_sincos_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .angle_vld_i (angle_vld_i),
        .angle_i     (angle_i),
        .res_vld_o   (res_vld_o),
        .cos_o       (cos_o),
        .sin_o       (sin_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int round_q14(input real v);
        real s;
        s = v * 16384.0;
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    endfunction

    task automatic check_valid(input bit ev, input string tag);
        total++;
        if (res_vld_o !== ev) begin
            bad++;
            $display("FAIL %s valid actual=%0b expected=%0b", tag, res_vld_o, ev);
        end
    endtask

    task automatic check_out(input bit ev, input int a, input string tag);
        real rad;
        int  ec;
        int  es;
        int  ac;
        int  as_;
        check_valid(ev, tag);
        if (ev) begin
            rad = real'($signed(a[15:0])) * PI_B / 32768.0;
            ec  = round_q14($cos(rad));
            es  = round_q14($sin(rad));
            ac  = int'(cos_o);
            as_ = int'(sin_o);
            total++;
            if (ac - ec > TOL || ec - ac > TOL) begin
                bad++;
                $display("FAIL %s cos angle=%0d actual=%0d expected=%0d", tag, $signed(a[15:0]), ac, ec);
            end
            total++;
            if (as_ - es > TOL || es - as_ > TOL) begin
                bad++;
                $display("FAIL %s sin angle=%0d actual=%0d expected=%0d", tag, $signed(a[15:0]), as_, es);
            end
        end
    endtask

    task automatic prime_history(input string tag);
        hv.delete();
        ha.delete();
        ht.delete();
        for (int i = 0; i < LAT; i++) begin
            hv.push_back(1'b0);
            ha.push_back(0);
            ht.push_back(tag);
        end
    endtask

    task automatic step(input bit v, input int a, input string tag);
        bit    ev;
        int    ea;
        string et;
        @(negedge clk);
        if (hv.size() == LAT) begin
            ev = hv.pop_front();
            ea = ha.pop_front();
            et = ht.pop_front();
            check_out(ev, ea, et);
        end
        angle_vld_i = v;
        angle_i     = a[15:0];
        hv.push_back(v);
        ha.push_back(a);
        ht.push_back(tag);
    endtask

    task automatic pulse_reset(input string tag);
        @(negedge clk);
        rst_n       = 1'b0;
        angle_vld_i = 1'b0;
        @(negedge clk);
        check_valid(1'b0, tag);
        rst_n = 1'b1;
        prime_history(tag);
    endtask

    initial begin
        rst_n       = 1'b0;
        angle_vld_i = 1'b0;
        angle_i     = '0;
        repeat (3) @(negedge clk);
        check_valid(1'b0, "R7 reset");
        rst_n = 1'b1;
        prime_history("R6 idle");

        // R3: isolated angles, result exactly LAT cycles later.
        step(1'b1, 5461, "R3 single");
        for (int i = 0; i < 20; i++) step(1'b0, 0, "R3 gap");
        step(1'b1, -3000, "R3 single");
        for (int i = 0; i < 5; i++) step(1'b0, 0, "R3 gap");

        // R1 R2 R4: back-to-back full-turn sweep.
        for (int i = 0; i < 140; i++) step(1'b1, -32768 + i * 467, "R1 R2 R4 sweep");

        // R5: quadrant boundaries and folded angles.
        step(1'b1, 16384,  "R5 plus-quarter");
        step(1'b1, -16384, "R5 minus-quarter");
        step(1'b1, 16383,  "R5 below-quarter");
        step(1'b1, -32768, "R5 minus-half");
        step(1'b1, 32767,  "R5 top-code");
        step(1'b1, 24576,  "R5 three-eighths");
        step(1'b1, -24576, "R5 minus-three-eighths");
        step(1'b1, 0,      "R2 zero");
        step(1'b1, 8192,   "R2 eighth");

        // R6: bubbles interleaved with valid angles.
        for (int i = 0; i < 30; i++) step((i % 3) != 1, i * 2111, "R6 bubbles");
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, "R6 drain");

        // R7: reset while angles are in flight, then nothing may emerge.
        for (int i = 0; i < 8; i++) step(1'b1, 1000 * i, "R7 inflight");
        pulse_reset("R7 flush");
        for (int i = 0; i < LAT + 4; i++) step(1'b0, 0, "R7 after-flush");
        step(1'b1, 12000, "R7 restart");
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 0, "R7 restart-drain");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule